// File: doc/BRIEF.md
# Four-channel DMA priority arbiter

This block decides which of four DMA channels owns the bus on each clock and keeps, per channel, the number of transfer units still owed and whether the channel has finished. Each registered grant pulse stands for one completed transfer unit. The block also keeps two sticky global halt flags, one raised by a non-maskable interrupt event and one by an address-error event. While either flag is set, no channel is granted.

A two-bit mode input selects the channel order. Three modes are fixed orders, one of which is deliberately irregular. The fourth mode rotates priority so that the last winner moves to the back of the queue. A per-channel mode bit picks between cycle-steal operation and burst operation. In cycle-steal operation the bus is re-arbitrated after every unit. In burst operation the current holder keeps the bus for as long as it stays eligible. Software loads the counters and clears the finished and halt flags through single-cycle strobes.

Top module: `dma_prio_arb`

## Requirements
- R1: While `rst_n` is low, the following are all 0: `grant`, `te_flag`, `irq`, `nmi_flag` and `aerr_flag`. The rotation pointer resets so that channel 0 is the first channel searched.
- R2: When `prio_mode` = 2'b00, the highest eligible channel is chosen in the order 0, 1, 2, 3.
- R3: When `prio_mode` = 2'b01, the highest eligible channel is chosen in the order 0, 2, 3, 1.
- R4: When `prio_mode` = 2'b10, the highest eligible channel is chosen in the order 2, 0, 1, 3.
- R5: When `prio_mode` = 2'b11, the search starts at the channel after the most recent winner (modulo 4) and proceeds upward. The most recent winner is recorded in every mode.
- R6: A channel is eligible only when all of these hold:
  - `master_en` is 1, and `ch_en[i]` and `ch_req[i]` are 1;
  - `te_flag[i]` is 0;
  - both `nmi_flag` and `aerr_flag` are 0.
  `grant` is a registered one-hot (or zero) vector that appears on the clock after the inputs that caused it.
- R7: An `nmi_evt` pulse sets `nmi_flag` and an `aerr_evt` pulse sets `aerr_flag` on the next clock. Each flag stays set until its clear strobe (`nmi_clr` or `aerr_clr`) is seen, and a set in the same cycle beats a clear. While either flag is set, no new grant is issued.
- R8: A `cnt_load[i]` pulse loads `cnt_val` into the counter of channel i, and each grant of channel i decrements that counter. When a grant consumes the last unit (count 1), `te_flag[i]` sets in the same cycle that grant appears. A load in the same cycle takes priority over the decrement and prevents the flag from setting. A loaded value of 0 means 2^CNT_W units.
- R9: `irq[i]` is 1 exactly when `te_flag[i]` and `ch_int_en[i]` are both 1.
- R10: A channel with `ch_burst[i]` = 1 that currently holds the grant keeps it on the next clock whenever it is still eligible, regardless of the priority of other requests. With `ch_burst[i]` = 0, every unit is arbitrated afresh.
- R11: A `te_clr[i]` strobe clears `te_flag[i]` on the next clock, unless a final-unit grant for that channel sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | Global enable for all channels |
| prio_mode | input | 2 | Channel order selection (00, 01, 10 fixed; 11 rotating) |
| ch_req | input | 4 | Per-channel transfer request |
| ch_en | input | 4 | Per-channel enable |
| ch_burst | input | 4 | Per-channel burst mode (1) or cycle-steal mode (0) |
| ch_int_en | input | 4 | Per-channel completion interrupt enable |
| cnt_load | input | 4 | Per-channel counter load strobe |
| cnt_val | input | CNT_W | Value to load into the counter |
| te_clr | input | 4 | Per-channel finished-flag clear strobe |
| nmi_evt | input | 1 | Non-maskable interrupt event pulse |
| nmi_clr | input | 1 | Clear strobe for the NMI halt flag |
| aerr_evt | input | 1 | Address-error event pulse |
| aerr_clr | input | 1 | Clear strobe for the address-error halt flag |
| grant | output | 4 | Registered one-hot grant, one transfer unit per pulse |
| te_flag | output | 4 | Per-channel transfer-end flag |
| irq | output | 4 | Per-channel completion interrupt request |
| nmi_flag | output | 1 | NMI halt flag |
| aerr_flag | output | 1 | Address-error halt flag |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, the three default fixed orders, and rotation enabled. All four priority modes and the burst-hold path are therefore live. Loaded counts are kept between 1 and 6, so channels run out of units within a few cycles. This exercises the finished flag, the interrupt and the same-cycle load, clear and set conflicts many times. The counter is wide enough that an unloaded channel never reaches zero during the run. The wrap path taken by a zero load is therefore reached only as a long decrement, not as a completion.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   localparam int unsigned NCH  = 4;
   localparam int unsigned CH_W = 2;

   typedef logic [CH_W-1:0]     ch_idx_t;
   typedef logic [NCH*CH_W-1:0] order_t;

   typedef enum logic [1:0] {
      PM_ORDER_A = 2'b00,
      PM_ORDER_B = 2'b01,
      PM_ORDER_C = 2'b10,
      PM_ROTATE  = 2'b11
   } prio_mode_e;

   // Slot 0 holds the highest-priority channel.
   function automatic order_t rotate_after(ch_idx_t last);
      order_t o;
      o = '0;
      for (int unsigned k = 0; k < NCH; k++) begin
         o[k*CH_W +: CH_W] = last + ch_idx_t'(k + 1);
      end
      return o;
   endfunction

   function automatic bit is_permutation(order_t o);
      logic [NCH-1:0] seen;
      seen = '0;
      for (int unsigned k = 0; k < NCH; k++) begin
         seen[o[k*CH_W +: CH_W]] = 1'b1;
      end
      return &seen;
   endfunction

endpackage

// File: rtl/dma_sticky_flag.sv
module dma_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             unit_i,
   input  logic             te_clr_i,
   output logic             te_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             last_unit;

   assign last_unit = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (unit_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_o <= 1'b0;
      end else if (unit_i && !load_i && last_unit) begin
         te_o <= 1'b1;
      end else if (te_clr_i) begin
         te_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_order_sel.sv
module dma_order_sel
   import dma_arb_pkg::*;
#(
   parameter order_t ORDER_A   = 8'hE4,
   parameter order_t ORDER_B   = 8'h78,
   parameter order_t ORDER_C   = 8'hD2,
   parameter bit     RR_ENABLE = 1'b1
) (
   input  logic [1:0] mode_i,
   input  ch_idx_t    last_i,
   output order_t     order_o
);

   order_t rot_order;

   generate
      if (RR_ENABLE) begin : g_rot
         assign rot_order = rotate_after(last_i);
      end else begin : g_norot
         logic unused_last;
         assign unused_last = ^last_i;
         assign rot_order   = ORDER_A;
      end
   endgenerate

   always_comb begin
      case (prio_mode_e'(mode_i))
         PM_ORDER_A: order_o = ORDER_A;
         PM_ORDER_B: order_o = ORDER_B;
         PM_ORDER_C: order_o = ORDER_C;
         PM_ROTATE:  order_o = rot_order;
         default:    order_o = ORDER_A;
      endcase
   end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
   import dma_arb_pkg::*;
(
   input  order_t         order_i,
   input  logic [NCH-1:0] elig_i,
   input  logic [NCH-1:0] hold_i,
   output logic           win_vld_o,
   output ch_idx_t        win_idx_o
);

   logic [NCH-1:0] slot_elig;

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_slot
         assign slot_elig[k] = elig_i[order_i[k*CH_W +: CH_W]];
      end
   endgenerate

   always_comb begin
      win_idx_o = '0;
      for (int k = int'(NCH) - 1; k >= 0; k--) begin
         if (slot_elig[k]) begin
            win_idx_o = order_i[k*CH_W +: CH_W];
         end
      end
      // a burst holder overrides the order
      for (int i = int'(NCH) - 1; i >= 0; i--) begin
         if (hold_i[i]) begin
            win_idx_o = ch_idx_t'(i);
         end
      end
      win_vld_o = |slot_elig;
   end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
   import dma_arb_pkg::*;
#(
   parameter int unsigned CNT_W     = 24,
   parameter order_t      ORDER_A   = 8'hE4,
   parameter order_t      ORDER_B   = 8'h78,
   parameter order_t      ORDER_C   = 8'hD2,
   parameter bit          RR_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master_en,
   input  logic [1:0]       prio_mode,
   input  logic [NCH-1:0]   ch_req,
   input  logic [NCH-1:0]   ch_en,
   input  logic [NCH-1:0]   ch_burst,
   input  logic [NCH-1:0]   ch_int_en,
   input  logic [NCH-1:0]   cnt_load,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [NCH-1:0]   te_clr,
   input  logic             nmi_evt,
   input  logic             nmi_clr,
   input  logic             aerr_evt,
   input  logic             aerr_clr,
   output logic [NCH-1:0]   grant,
   output logic [NCH-1:0]   te_flag,
   output logic [NCH-1:0]   irq,
   output logic             nmi_flag,
   output logic             aerr_flag
);

   localparam ch_idx_t LAST_RST = ch_idx_t'(NCH - 1);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("dma_prio_arb: CNT_W must be at least 2");
      end
      if (!is_permutation(ORDER_A) || !is_permutation(ORDER_B) ||
          !is_permutation(ORDER_C)) begin : g_bad_order
         $error("dma_prio_arb: every fixed order must name each channel once");
      end
   endgenerate

   logic [NCH-1:0] elig;
   logic [NCH-1:0] hold;
   logic [NCH-1:0] grant_d;
   logic [NCH-1:0] grant_q;
   logic           run_ok;
   logic           win_vld;
   ch_idx_t        win_idx;
   ch_idx_t        last_q;
   order_t         order;

   assign run_ok = master_en & ~nmi_flag & ~aerr_flag;
   assign elig   = {NCH{run_ok}} & ch_en & ch_req & ~te_flag;
   assign hold   = grant_q & ch_burst & elig;

   dma_order_sel #(
      .ORDER_A   (ORDER_A),
      .ORDER_B   (ORDER_B),
      .ORDER_C   (ORDER_C),
      .RR_ENABLE (RR_ENABLE)
   ) u_order (
      .mode_i  (prio_mode),
      .last_i  (last_q),
      .order_o (order)
   );

   dma_prio_pick u_pick (
      .order_i   (order),
      .elig_i    (elig),
      .hold_i    (hold),
      .win_vld_o (win_vld),
      .win_idx_o (win_idx)
   );

   always_comb begin
      grant_d = '0;
      if (win_vld) begin
         grant_d = NCH'(1) << win_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         last_q  <= LAST_RST;
      end else begin
         grant_q <= grant_d;
         if (win_vld) begin
            last_q <= win_idx;
         end
      end
   end

   dma_sticky_flag u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (nmi_evt),
      .clr_i  (nmi_clr),
      .flag_o (nmi_flag)
   );

   dma_sticky_flag u_aerr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (aerr_evt),
      .clr_i  (aerr_clr),
      .flag_o (aerr_flag)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dma_chan_ctr #(
            .CNT_W (CNT_W)
         ) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (cnt_load[i]),
            .load_val_i (cnt_val),
            .unit_i     (grant_d[i]),
            .te_clr_i   (te_clr[i]),
            .te_o       (te_flag[i])
         );
      end
   endgenerate

   assign grant = grant_q;
   assign irq   = te_flag & ch_int_en;

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk
   import dma_arb_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             master_en,
   input logic [1:0]       prio_mode,
   input logic [NCH-1:0]   ch_req,
   input logic [NCH-1:0]   ch_en,
   input logic [NCH-1:0]   ch_burst,
   input logic [NCH-1:0]   ch_int_en,
   input logic [NCH-1:0]   cnt_load,
   input logic [CNT_W-1:0] cnt_val,
   input logic [NCH-1:0]   te_clr,
   input logic             nmi_evt,
   input logic             nmi_clr,
   input logic             aerr_evt,
   input logic             aerr_clr,
   input logic [NCH-1:0]   grant,
   input logic [NCH-1:0]   te_flag,
   input logic [NCH-1:0]   irq,
   input logic             nmi_flag,
   input logic             aerr_flag
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (grant == '0 && te_flag == '0 && !nmi_flag && !aerr_flag));

   assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_needs_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> $past(master_en));

   assert_nmi_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_evt |=> nmi_flag);

   assert_aerr_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      aerr_evt |=> aerr_flag);

   assert_nmi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_flag && !nmi_clr) |=> nmi_flag);

   assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_flag || aerr_flag) |=> (grant == '0));

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chk
         assert_te_with_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(te_flag[i]) |-> grant[i]);

         assert_te_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            te_clr[i] |=> (!te_flag[i] || grant[i]));

         assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && ch_burst[i] && ch_req[i] && ch_en[i] && master_en &&
             !te_flag[i] && !nmi_flag && !aerr_flag) |=> grant[i]);
      end
   endgenerate

   logic unused_inputs;
   assign unused_inputs = ^{prio_mode, ch_int_en, cnt_load, cnt_val, aerr_clr, irq};

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;

   localparam int CW = 24;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          master_en;
   logic [1:0]    prio_mode;
   logic [3:0]    ch_req, ch_en, ch_burst, ch_int_en, cnt_load, te_clr;
   logic [CW-1:0] cnt_val;
   logic          nmi_evt, nmi_clr, aerr_evt, aerr_clr;
   logic [3:0]    grant, te_flag, irq;
   logic          nmi_flag, aerr_flag;

   int checks = 0;
   int errors = 0;

   // reference state
   logic [CW-1:0] m_cnt [4];
   logic [3:0]    m_te;
   logic [3:0]    m_gnt;
   int            m_last;
   logic          m_nmi, m_aerr;
   string         ph;

   always #5 clk = ~clk;

   dma_prio_arb dut (.*);

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int order_slot(logic [1:0] mode, int last, int k);
      case (mode)
         2'b00: return k;
         2'b01: case (k) 0: return 0; 1: return 2; 2: return 3; default: return 1; endcase
         2'b10: case (k) 0: return 2; 1: return 0; 2: return 1; default: return 3; endcase
         default: return (last + 1 + k) % 4;
      endcase
   endfunction

   task automatic model_step();
      logic [3:0] el;
      int win;
      win = -1;
      for (int i = 0; i < 4; i++)
         el[i] = master_en && ch_en[i] && ch_req[i] && !m_te[i] && !m_nmi && !m_aerr;
      for (int i = 0; i < 4; i++)
         if (m_gnt[i] && ch_burst[i] && el[i]) win = i;
      if (win < 0)
         for (int k = 0; k < 4; k++) begin
            int c;
            c = order_slot(prio_mode, m_last, k);
            if (win < 0 && el[c]) win = c;
         end
      for (int i = 0; i < 4; i++) begin
         logic set;
         set = (win == i) && !cnt_load[i] && (m_cnt[i] == CW'(1));
         if (cnt_load[i]) m_cnt[i] = cnt_val;
         else if (win == i) m_cnt[i] = m_cnt[i] - CW'(1);
         if (set) m_te[i] = 1'b1;
         else if (te_clr[i]) m_te[i] = 1'b0;
      end
      m_gnt = (win >= 0) ? (4'b0001 << win) : 4'b0000;
      if (win >= 0) m_last = win;
      m_nmi  = nmi_evt  ? 1'b1 : (nmi_clr  ? 1'b0 : m_nmi);
      m_aerr = aerr_evt ? 1'b1 : (aerr_clr ? 1'b0 : m_aerr);
   endtask

   task automatic compare();
      string gtag;
      if (ph != "") gtag = ph;
      else case (prio_mode)
         2'b00: gtag = "R2 grant";
         2'b01: gtag = "R3 grant";
         2'b10: gtag = "R4 grant";
         default: gtag = "R5 grant";
      endcase
      check(gtag, 32'(grant), 32'(m_gnt));
      check("R8/R11 te_flag", 32'(te_flag), 32'(m_te));
      check("R9 irq", 32'(irq), 32'(m_te & ch_int_en));
      check("R7 nmi_flag", 32'(nmi_flag), 32'(m_nmi));
      check("R7 aerr_flag", 32'(aerr_flag), 32'(m_aerr));
   endtask

   task automatic step();
      model_step();
      @(negedge clk);
      compare();
      cnt_load = '0; te_clr = '0;
      nmi_evt = 0; nmi_clr = 0; aerr_evt = 0; aerr_clr = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0D3A));
      rst_n = 0; master_en = 0; prio_mode = 0; ch_req = 0; ch_en = 0;
      ch_burst = 0; ch_int_en = 0; cnt_load = 0; te_clr = 0; cnt_val = 0;
      nmi_evt = 0; nmi_clr = 0; aerr_evt = 0; aerr_clr = 0;
      for (int i = 0; i < 4; i++) m_cnt[i] = '0;
      m_te = 0; m_gnt = 0; m_last = 3; m_nmi = 0; m_aerr = 0; ph = "";
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 grant", 32'(grant), 0);
      check("R1 te_flag", 32'(te_flag), 0);
      check("R1 irq", 32'(irq), 0);
      check("R1 flags", 32'({nmi_flag, aerr_flag}), 0);
      rst_n = 1;

      // load all channels, every channel requesting
      cnt_val = 20; cnt_load = 4'hF; step();
      master_en = 1; ch_en = 4'hF; ch_req = 4'hF;
      ph = "R2 order 0>1>2>3"; prio_mode = 2'b00; step(); step();
      check("R2 channel 0 wins", 32'(grant), 32'h1);
      ch_req = 4'b1110; step();
      check("R2 channel 1 next", 32'(grant), 32'h2);
      ph = "R3 order 0>2>3>1"; prio_mode = 2'b01; ch_req = 4'b1010; step();
      check("R3 channel 3 above 1", 32'(grant), 32'h8);
      ph = "R4 order 2>0>1>3"; prio_mode = 2'b10; ch_req = 4'b0111; step();
      check("R4 channel 2 first", 32'(grant), 32'h4);
      ch_req = 4'b0011; step();
      check("R4 channel 0 over 1", 32'(grant), 32'h1);
      ph = "R5 rotation"; prio_mode = 2'b11; ch_req = 4'hF;
      step(); check("R5 after 0 comes 1", 32'(grant), 32'h2);
      step(); check("R5 after 1 comes 2", 32'(grant), 32'h4);
      step(); step(); step();
      ph = "R6 master off"; master_en = 0; step(); step();
      check("R6 no grant without master", 32'(grant), 0);
      master_en = 1; ch_en = 4'b0100; step();
      ph = "R6 disabled channels"; ch_req = 4'b1011; step();
      check("R6 only enabled requester", 32'(grant), 0);
      ch_en = 4'hF;
      ph = "R7 nmi halt"; nmi_evt = 1; step(); step(); step();
      check("R7 halted", 32'(grant), 0);
      nmi_clr = 1; step(); step();
      ph = "R7 aerr halt"; aerr_evt = 1; nmi_clr = 1; step(); step();
      aerr_clr = 1; aerr_evt = 1; step(); step();
      aerr_clr = 1; step(); step();

      // R10 burst hold
      ph = "R10 burst"; prio_mode = 2'b00; te_clr = 4'hF; cnt_val = 3; cnt_load = 4'hF;
      ch_req = 0; step();
      ch_burst = 4'b1000; ch_req = 4'b1000; step();
      ch_req = 4'hF; step();
      check("R10 burst holder keeps bus", 32'(grant), 32'h8);
      step(); step(); step();
      ch_burst = 0;

      // R8 / R9 / R11 final unit, interrupt and clear
      ph = "R8 last unit"; te_clr = 4'hF; ch_req = 0; step();
      cnt_val = 1; cnt_load = 4'b0001; ch_int_en = 4'b0001; step();
      ch_req = 4'b0001; step();
      check("R8 te with last grant", 32'(te_flag[0]), 1);
      check("R9 irq from te", 32'(irq[0]), 1);
      ph = "R11 clear"; step(); te_clr = 4'b0001; step();
      check("R11 te cleared", 32'(te_flag[0]), 0);
      step(); step();

      // constrained random traffic
      ph = "";
      for (int n = 0; n < 4000; n++) begin
         if (n % 32 == 0) prio_mode = 2'($urandom % 4);
         master_en = ($urandom % 10) != 0;
         ch_en     = 4'($urandom) | 4'($urandom);
         ch_req    = 4'($urandom) | 4'($urandom);
         ch_burst  = 4'($urandom) & 4'($urandom);
         ch_int_en = 4'($urandom);
         cnt_val   = CW'(1 + $urandom % 6);
         for (int i = 0; i < 4; i++) begin
            cnt_load[i] = ($urandom % 6) == 0;
            te_clr[i]   = ($urandom % 5) == 0;
         end
         nmi_evt  = ($urandom % 97) == 0;
         nmi_clr  = ($urandom % 6) == 0;
         aerr_evt = ($urandom % 89) == 0;
         aerr_clr = ($urandom % 6) == 0;
         step();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule